// File: doc/BRIEF.md
# Condition Code and Branch PC Unit

This block keeps a two-bit condition state, negative and zero, taken from the result of each arithmetic or logic instruction. It uses that state to decide branches and to choose the next program counter. The execute stage presents the result together with an update strobe. The state is written on the next rising clock edge and is held until the next strobe. Relational branches work on the state left by an earlier subtraction of the second operand from the first. A set sign bit means the first operand was the smaller one. A set zero bit means the two operands were equal.

On every cycle the unit looks at a 4-bit branch code, a branch-valid strobe, the target address carried in the instruction, and the current program counter. From these it produces the next program counter and a taken flag, both through combinational logic. When the branch is taken, the next PC is the target. Otherwise it is the current PC plus one, and it wraps at the top of the address range.

Top module: `ccb_unit`

## Requirements
- R1: On a rising edge with `flag_upd` high and `rst` low, the negative flag takes the MSB of `alu_result`.
- R2: On the same edge, the zero flag is set only when every bit of `alu_result` is 0.
- R3: While `flag_upd` is low, both flags keep their values whatever `alu_result` does.
- R4: A rising edge with `rst` high (synchronous, active high) clears both flags to 0.
- R5: With N the negative flag and Z the zero flag, the branch codes decide as follows: 1 = LT, also used as branch-if-negative (N). 2 = GE, also used as branch-if-positive (!N). 3 = EQ (Z). 4 = NE (!Z). 5 = GT (!N && !Z). 6 = LE (N || Z).
- R6: Code 0 is an unconditional branch, taken whenever `br_valid` is high.
- R7: When `br_taken` is high, `pc_next` equals `br_target`.
- R8: When `br_taken` is low, `pc_next` equals `pc_cur + 1` modulo 2^ADDR_W.
- R9: `br_taken` is high only while `br_valid` is high and the selected condition holds.
- R10: Codes 7 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_result | input | DATA_W | Result of the current ALU operation |
| flag_upd | input | 1 | Write the flags from `alu_result` on this edge |
| br_code | input | 4 | Branch condition selector |
| br_valid | input | 1 | A branch instruction is being resolved |
| br_target | input | ADDR_W | Branch address from the instruction |
| pc_cur | input | ADDR_W | Current program counter |
| pc_next | output | ADDR_W | Selected next program counter |
| br_taken | output | 1 | The branch is taken |

## Verification
The assertions check on every cycle that the flags are captured and held correctly and that reset clears them. They also check that a taken branch always comes with `br_valid`, that `pc_next` follows the target when taken and the increment when not, and that code 0 and the unused codes behave as required. Only the bench scenarios can show that each relational code gives the correct signed ordering of two operands through a prior subtraction. They also show that the flags survive changes of the result bus without a strobe, and that the increment wraps at the top address.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

    typedef enum logic [3:0] {
        BC_ALWAYS = 4'd0,
        BC_LT     = 4'd1,
        BC_GE     = 4'd2,
        BC_EQ     = 4'd3,
        BC_NE     = 4'd4,
        BC_GT     = 4'd5,
        BC_LE     = 4'd6
    } br_code_e;

    typedef struct packed {
        logic neg;
        logic zero;
    } cc_flags_t;

    localparam cc_flags_t CC_CLEAR = '{neg: 1'b0, zero: 1'b0};

    function automatic logic cond_holds(input logic [3:0] code, input cc_flags_t f);
        logic r;
        case (code)
            BC_ALWAYS: r = 1'b1;
            BC_LT:     r = f.neg;
            BC_GE:     r = !f.neg;
            BC_EQ:     r = f.zero;
            BC_NE:     r = !f.zero;
            BC_GT:     r = !f.neg && !f.zero;
            BC_LE:     r = f.neg || f.zero;
            default:   r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ccb_flag_reg.sv
module ccb_flag_reg
    import ccb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] result,
    input  logic              upd,
    output cc_flags_t         flags
);
    localparam int MSB = DATA_W - 1;

    cc_flags_t flags_q;
    cc_flags_t flags_d;

    always_comb begin
        flags_d      = flags_q;
        if (upd) begin
            flags_d.neg  = result[MSB];
            flags_d.zero = (result == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= CC_CLEAR;
        else     flags_q <= flags_d;
    end

    assign flags = flags_q;

    // R1
    neg_cap_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (flags_q.neg == $past(result[MSB])));

    // R2
    zero_cap_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (flags_q.zero == ($past(result) == '0)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !upd |=> $stable(flags_q));

    // R4
    rst_clr_chk: assert property (@(posedge clk)
        rst |=> (flags_q == CC_CLEAR));

endmodule

// File: rtl/ccb_cond_eval.sv
module ccb_cond_eval
    import ccb_pkg::*;
(
    input  logic [3:0] code,
    input  logic       valid,
    input  cc_flags_t  flags,
    output logic       taken
);
    always_comb taken = valid && cond_holds(code, flags);
endmodule

// File: rtl/ccb_pc_sel.sv
module ccb_pc_sel #(
    parameter int ADDR_W  = 8,
    parameter int PC_STEP = 1
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] target,
    input  logic              taken,
    output logic [ADDR_W-1:0] pc_next
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

    logic [ADDR_W-1:0] pc_inc;

    always_comb begin
        pc_inc  = pc_cur + STEP;
        pc_next = taken ? target : pc_inc;
    end
endmodule

// File: rtl/ccb_unit.sv
module ccb_unit
    import ccb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              flag_upd,
    input  logic [3:0]        br_code,
    input  logic              br_valid,
    input  logic [ADDR_W-1:0] br_target,
    input  logic [ADDR_W-1:0] pc_cur,
    output logic [ADDR_W-1:0] pc_next,
    output logic              br_taken
);
    cc_flags_t flags;

    ccb_flag_reg #(.DATA_W(DATA_W)) u_flags (
        .clk(clk), .rst(rst), .result(alu_result), .upd(flag_upd), .flags(flags)
    );

    ccb_cond_eval u_cond (
        .code(br_code), .valid(br_valid), .flags(flags), .taken(br_taken)
    );

    ccb_pc_sel #(.ADDR_W(ADDR_W), .PC_STEP(1)) u_pcsel (
        .pc_cur(pc_cur), .target(br_target), .taken(br_taken), .pc_next(pc_next)
    );

    // R9
    taken_valid_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> br_valid);

    // R7
    taken_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (pc_next == br_target));

    // R8
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (pc_next == ADDR_W'(pc_cur + 1'b1)));

    // R6
    always_chk: assert property (@(posedge clk) disable iff (rst)
        (br_valid && br_code == 4'd0) |-> br_taken);

    // R10
    unused_code_chk: assert property (@(posedge clk) disable iff (rst)
        (br_code > 4'd6) |-> !br_taken);

endmodule

// File: tb/ccb_unit_bench.sv
module ccb_unit_bench;
    localparam int DW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [DW-1:0] alu_result = '0;
    logic          flag_upd = 1'b0;
    logic [3:0]    br_code = '0;
    logic          br_valid = 1'b0;
    logic [AW-1:0] br_target = '0;
    logic [AW-1:0] pc_cur = '0;
    logic [AW-1:0] pc_next;
    logic          br_taken;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    ccb_unit #(.DATA_W(DW), .ADDR_W(AW)) u_ccb_unit (
        .clk(clk), .rst(rst), .alu_result(alu_result), .flag_upd(flag_upd),
        .br_code(br_code), .br_valid(br_valid), .br_target(br_target),
        .pc_cur(pc_cur), .pc_next(pc_next), .br_taken(br_taken)
    );

    task automatic chk(input string req, input logic [AW:0] act, input logic [AW:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic load_flags(input logic [DW-1:0] v);
        @(negedge clk);
        alu_result = v;
        flag_upd   = 1'b1;
        @(negedge clk);
        flag_upd   = 1'b0;
        alu_result = ~v ^ 16'h5a5a;   // garbage while held (R3)
        @(negedge clk);
        alu_result = 16'h0;
    endtask

    function automatic logic exp_taken(input int code, input int a, input int b, input logic vld);
        logic r;
        case (code)
            0: r = 1'b1;
            1: r = (a < b);
            2: r = (a >= b);
            3: r = (a == b);
            4: r = (a != b);
            5: r = (a > b);
            6: r = (a <= b);
            default: r = 1'b0;
        endcase
        return vld && r;
    endfunction

    task automatic eval(input int code, input logic vld, input logic [AW-1:0] pc,
                        input logic [AW-1:0] tgt, input logic et, input string req);
        logic [AW-1:0] ep;
        br_code   = 4'(code);
        br_valid  = vld;
        pc_cur    = pc;
        br_target = tgt;
        #1;
        ep = et ? tgt : AW'(pc + 1);
        chk({req, " taken"}, {{AW{1'b0}}, br_taken}, {{AW{1'b0}}, et});
        chk({req, " pc_next"}, {1'b0, pc_next}, {1'b0, ep});
    endtask

    initial begin
        #(8 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R4: after reset N=0 Z=0: GT taken, EQ and LT not taken
        eval(5, 1'b1, 8'h10, 8'h80, 1'b1, "R4 reset GT");
        eval(3, 1'b1, 8'h10, 8'h80, 1'b0, "R4 reset EQ");
        eval(1, 1'b1, 8'h10, 8'h80, 1'b0, "R4 reset LT");

        // R1 R2 R3 R5 R6 R9 R10: sweep operands through a prior subtraction
        for (int a = -3; a <= 3; a++) begin
            for (int b = -3; b <= 3; b++) begin
                load_flags(DW'(a - b));
                for (int c = 0; c < 16; c++) begin
                    for (int v = 0; v < 2; v++) begin
                        string tag;
                        tag = (c == 0) ? "R6" : (c > 6) ? "R10" : (v == 0) ? "R9" : "R5/R1/R2/R3";
                        eval(c, v[0], AW'(a * 7 + b + 40), AW'(c * 11 + 3),
                             exp_taken(c, a, b, v[0]), tag);
                    end
                end
            end
        end

        // R1: MSB alone sets negative
        load_flags(16'h8000);
        eval(1, 1'b1, 8'h20, 8'h44, 1'b1, "R1 msb LT");
        eval(3, 1'b1, 8'h20, 8'h44, 1'b0, "R2 nonzero EQ");
        // R2: single low bit clears zero
        load_flags(16'h0001);
        eval(4, 1'b1, 8'h20, 8'h44, 1'b1, "R2 lsb NE");
        eval(5, 1'b1, 8'h20, 8'h44, 1'b1, "R1 pos GT");

        // R8 / R7: wrap at top address and target selection
        eval(3, 1'b1, 8'hFF, 8'h12, 1'b0, "R8 wrap");
        eval(0, 1'b1, 8'hFF, 8'h12, 1'b1, "R7 target");
        eval(0, 1'b0, 8'h7F, 8'h12, 1'b0, "R8 increment");

        // R4: reset again after setting flags to negative
        load_flags(16'hFFFF);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        eval(2, 1'b1, 8'h01, 8'h99, 1'b1, "R4 re-reset GE");
        eval(6, 1'b1, 8'h01, 8'h99, 1'b0, "R4 re-reset LE");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule